// File: doc/BRIEF.md
# Multicarrier PWM Level Generator

This block drives the level selection of a multilevel inverter. It builds a stack of level-shifted digital triangular carriers and compares every one of them against a single signed reference sample. It then adds up the comparator results into a level index in the range 0 to LEVELS-1. For an inverter with LEVELS output steps there are LEVELS-1 carriers. All of them share one up/down phase counter, and carrier k sits in band k of a common unsigned scale.

The reference arrives as a signed sample stream from an external sine source. It is scaled by an amplitude setting and then shifted into offset binary, so that it lies on the same scale as the carrier stack. A programmable prescaler sets how many clocks pass per carrier step. This sets the carrier frequency and, with the reference rate, the frequency modulation ratio. On every carrier step the comparator vector and the level index are registered, and a one-cycle strobe marks the update.

Top module: `mcpwm_level_gen`

## Requirements
- R1: The comparator vector has LEVELS-1 bits. Bit k is 1 exactly when the mapped reference is strictly greater than carrier k, where carrier k equals k*2^CAR_W + phase.
- R2: The mapped reference equals ((floor(ref*amp / 2^AMP_W) + 2^(REF_W-1)) * (LEVELS-1)*2^CAR_W) >> REF_W, with ref signed and amp unsigned.
- R3: The level index equals the number of set bits in the comparator vector latched at the same update, and it never exceeds LEVELS-1.
- R4: The shared phase counts 0,1,...,2^CAR_W-1 and then back down to 0, one step per carrier tick. Each end value appears once per turn.
- R5: A carrier tick occurs when the prescale count is at or above div_cfg; after a tick the count restarts at 0. strobe_o is high for exactly the cycle after each tick.
- R6: Between strobes the comparator vector and the level index hold their values.
- R7: While rst_n is low, all outputs are 0, the phase is 0 and counting up, and the prescale count is 0. After release the first carrier tick can come at the third rising edge.
- R8: The comparator vector is always a thermometer code: if bit k is set, every lower bit is set.
- R9: If div_cfg is lowered below the running prescale count, a tick occurs on the next clock edge.
- R10: With amp equal to 0 the mapped reference is the scale midpoint, and the level index equals (LEVELS-1)/2 rounded down whenever LEVELS-1 is even.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_i | input | REF_W | Signed reference sample |
| amp_i | input | AMP_W | Amplitude setting, gain amp/2^AMP_W |
| div_cfg_i | input | DIV_W | Clocks per carrier step minus one |
| level_o | output | LVL_W | Output voltage level index |
| cmp_o | output | LEVELS-1 | Raw comparator vector, bit k for carrier k |
| strobe_o | output | 1 | One-cycle update marker |

## Verification
The bench builds the block with its defaults: five levels, a 4-bit carrier phase, a 12-bit reference and an 8-bit amplitude. With these values a full carrier turn takes only 30 ticks, so hundreds of reversals at both phase ends occur within the run. A small divider range puts ticks on every cycle as well as sparse ticks. Amplitude corners at zero and full scale drive the mapped reference onto the exact midpoint and onto the top and bottom bands, where comparator ties against carrier edges become reachable.

// File: rtl/mcpwm_pkg.sv
package mcpwm_pkg;
  typedef enum logic {DIR_UP = 1'b0, DIR_DOWN = 1'b1} ramp_dir_e;
endpackage

// File: rtl/mcpwm_rst_sync.sv
module mcpwm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;
endmodule

// File: rtl/mcpwm_tick_gen.sv
module mcpwm_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;

  always_comb begin
    tick_o = (cnt_q >= div_i);
    cnt_d  = tick_o ? '0 : cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // R5
  tick_restart_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    tick_o |=> (tick_o == (div_i == '0)));
endmodule

// File: rtl/mcpwm_carrier_phase.sv
module mcpwm_carrier_phase
  import mcpwm_pkg::*;
#(
  parameter int CAR_W = 4
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [CAR_W-1:0] phase_o
);
  localparam logic [CAR_W-1:0] PH_MAX = {CAR_W{1'b1}};

  logic [CAR_W-1:0] phase_q, phase_d;
  ramp_dir_e        dir_q, dir_d;

  always_comb begin
    phase_d = phase_q;
    dir_d   = dir_q;
    if (tick_i) begin
      if (dir_q == DIR_UP) begin
        if (phase_q == PH_MAX) begin
          dir_d   = DIR_DOWN;
          phase_d = phase_q - CAR_W'(1);
        end else begin
          phase_d = phase_q + CAR_W'(1);
        end
      end else begin
        if (phase_q == '0) begin
          dir_d   = DIR_UP;
          phase_d = CAR_W'(1);
        end else begin
          phase_d = phase_q - CAR_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      dir_q   <= DIR_UP;
    end else if (tick_i) begin
      phase_q <= phase_d;
      dir_q   <= dir_d;
    end
  end

  assign phase_o = phase_q;

  // R4
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    tick_i |=> (({1'b0, phase_q} == {1'b0, $past(phase_q)} + (CAR_W+1)'(1)) ||
                ({1'b0, phase_q} + (CAR_W+1)'(1) == {1'b0, $past(phase_q)})));
  // R4
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !tick_i |=> $stable(phase_q));
endmodule

// File: rtl/mcpwm_ref_map.sv
module mcpwm_ref_map #(
  parameter int LEVELS  = 5,
  parameter int CAR_W   = 4,
  parameter int REF_W   = 12,
  parameter int AMP_W   = 8,
  parameter int SCALE_W = CAR_W + $clog2(LEVELS-1)
) (
  input  logic signed [REF_W-1:0] ref_i,
  input  logic [AMP_W-1:0]        amp_i,
  output logic [SCALE_W-1:0]      mapped_o
);
  localparam int PW = REF_W + AMP_W + 1;
  localparam int MW = REF_W + SCALE_W + 1;
  localparam logic [SCALE_W:0] SPAN = (SCALE_W+1)'((LEVELS-1) * (2**CAR_W));

  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] scaled;
  logic [REF_W-1:0]     offset;
  logic [MW-1:0]        wide;

  always_comb begin
    prod   = PW'(ref_i) * PW'($signed({1'b0, amp_i}));
    scaled = prod >>> AMP_W;
    offset = scaled[REF_W-1:0] ^ {1'b1, {(REF_W-1){1'b0}}};
    wide   = {{(SCALE_W+1){1'b0}}, offset} * {{REF_W{1'b0}}, SPAN};
    mapped_o = wide[REF_W +: SCALE_W];
  end
endmodule

// File: rtl/mcpwm_cmp_bank.sv
module mcpwm_cmp_bank #(
  parameter int LEVELS  = 5,
  parameter int CAR_W   = 4,
  parameter int SCALE_W = CAR_W + $clog2(LEVELS-1),
  parameter int LVL_W   = $clog2(LEVELS)
) (
  input  logic [SCALE_W-1:0] mapped_i,
  input  logic [CAR_W-1:0]   phase_i,
  output logic [LEVELS-2:0]  cmp_o,
  output logic [LVL_W-1:0]   count_o
);
  localparam int NC = LEVELS - 1;

  for (genvar k = 0; k < NC; k++) begin : g_carrier
    localparam logic [SCALE_W-1:0] BASE = SCALE_W'(k * (2**CAR_W));
    logic [SCALE_W-1:0] carrier;
    assign carrier  = BASE | SCALE_W'(phase_i);
    assign cmp_o[k] = (mapped_i > carrier);
  end

  always_comb begin
    count_o = '0;
    for (int k = 0; k < NC; k++) begin
      count_o = count_o + LVL_W'(cmp_o[k]);
    end
  end
endmodule

// File: rtl/mcpwm_level_gen.sv
module mcpwm_level_gen #(
  parameter int LEVELS  = 5,
  parameter int CAR_W   = 4,
  parameter int REF_W   = 12,
  parameter int AMP_W   = 8,
  parameter int DIV_W   = 8,
  parameter int LVL_W   = $clog2(LEVELS),
  parameter int SCALE_W = CAR_W + $clog2(LEVELS-1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [REF_W-1:0] ref_i,
  input  logic [AMP_W-1:0]        amp_i,
  input  logic [DIV_W-1:0]        div_cfg_i,
  output logic [LVL_W-1:0]        level_o,
  output logic [LEVELS-2:0]       cmp_o,
  output logic                    strobe_o
);
  localparam int NC = LEVELS - 1;

  logic               rst_ni;
  logic               tick;
  logic [CAR_W-1:0]   phase;
  logic [SCALE_W-1:0] mapped;
  logic [NC-1:0]      cmp_now;
  logic [LVL_W-1:0]   count_now;

  logic [NC-1:0]    cmp_q, cmp_d;
  logic [LVL_W-1:0] level_q, level_d;
  logic             strobe_q, strobe_d;

  mcpwm_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_ni)
  );

  mcpwm_tick_gen #(.DIV_W(DIV_W)) i_tick_gen (
    .clk    (clk),
    .rst_ni (rst_ni),
    .div_i  (div_cfg_i),
    .tick_o (tick)
  );

  mcpwm_carrier_phase #(.CAR_W(CAR_W)) i_phase (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .phase_o (phase)
  );

  mcpwm_ref_map #(
    .LEVELS(LEVELS), .CAR_W(CAR_W), .REF_W(REF_W), .AMP_W(AMP_W), .SCALE_W(SCALE_W)
  ) i_ref_map (
    .ref_i    (ref_i),
    .amp_i    (amp_i),
    .mapped_o (mapped)
  );

  mcpwm_cmp_bank #(
    .LEVELS(LEVELS), .CAR_W(CAR_W), .SCALE_W(SCALE_W), .LVL_W(LVL_W)
  ) i_cmp_bank (
    .mapped_i (mapped),
    .phase_i  (phase),
    .cmp_o    (cmp_now),
    .count_o  (count_now)
  );

  always_comb begin
    cmp_d    = cmp_q;
    level_d  = level_q;
    strobe_d = tick;
    if (tick) begin
      cmp_d   = cmp_now;
      level_d = count_now;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q    <= '0;
      level_q  <= '0;
      strobe_q <= 1'b0;
    end else begin
      cmp_q    <= cmp_d;
      level_q  <= level_d;
      strobe_q <= strobe_d;
    end
  end

  assign cmp_o    = cmp_q;
  assign level_o  = level_q;
  assign strobe_o = strobe_q;

  // R8
  thermo_code_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    ((cmp_q + NC'(1)) & cmp_q) == '0);
  // R3
  level_max_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    level_q <= LVL_W'(LEVELS-1));
  // R5
  strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    tick |=> strobe_q);
  // R5
  strobe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !tick |=> !strobe_q);
  // R6
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !tick |=> ($stable(level_q) && $stable(cmp_q)));
  // R7
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |-> (level_q == '0 && cmp_q == '0 && !strobe_q));
endmodule

// File: tb/test_mcpwm_level_gen.sv
module test_mcpwm_level_gen;
  localparam int LEVELS = 5;
  localparam int CAR_W  = 4;
  localparam int REF_W  = 12;
  localparam int AMP_W  = 8;
  localparam int DIV_W  = 8;
  localparam int LVL_W  = $clog2(LEVELS);
  localparam int NC     = LEVELS - 1;
  localparam int PHMAX  = (1 << CAR_W) - 1;

  logic clk = 1'b0;
  logic rst_n;
  logic signed [REF_W-1:0] ref_s;
  logic [AMP_W-1:0] amp;
  logic [DIV_W-1:0] div;
  logic [LVL_W-1:0] level;
  logic [NC-1:0]    cmp;
  logic             strobe;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  int mcnt, mphase, mdir;
  logic [NC-1:0]    exp_vec;
  logic [LVL_W-1:0] exp_lvl;
  logic             exp_stb;

  always #5 clk = ~clk;

  mcpwm_level_gen i_mcpwm_level_gen (
    .clk(clk), .rst_n(rst_n), .ref_i(ref_s), .amp_i(amp), .div_cfg_i(div),
    .level_o(level), .cmp_o(cmp), .strobe_o(strobe)
  );

  // R2 mapping computed from the requirement
  function automatic longint map_ref(longint r, longint a);
    longint sc;
    sc = (r * a) >>> AMP_W;
    return ((sc + (longint'(1) << (REF_W-1))) * (NC * (PHMAX + 1))) >>> REF_W;
  endfunction

  // R1 comparator vector from stacked carriers
  function automatic logic [NC-1:0] vec_of(longint m, int ph);
    logic [NC-1:0] v;
    for (int k = 0; k < NC; k++) v[k] = (m > longint'(k * (PHMAX + 1) + ph));
    return v;
  endfunction

  function automatic int ones(logic [NC-1:0] v);
    int c = 0;
    for (int k = 0; k < NC; k++) c += int'(v[k]);
    return c;
  endfunction

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    mcnt = 0; mphase = 0; mdir = 0;
    exp_vec = '0; exp_lvl = '0; exp_stb = 1'b0;
  endtask

  // one cycle: check what the last edge produced, drive, predict the next edge
  task automatic step(logic signed [REF_W-1:0] r, logic [AMP_W-1:0] a, logic [DIV_W-1:0] d);
    @(negedge clk);
    check(exp_stb ? "R1 R2 R4 vector" : "R6 vector hold", longint'(cmp), longint'(exp_vec));
    check(exp_stb ? "R3 level" : "R6 level hold", longint'(level), longint'(exp_lvl));
    check("R5 strobe", longint'(strobe), longint'(exp_stb));
    ref_s = r; amp = a; div = d;
    if (mcnt >= int'(d)) begin  // R5 / R9 tick rule
      exp_vec = vec_of(map_ref(longint'(r), longint'(a)), mphase);
      exp_lvl = LVL_W'(ones(exp_vec));
      exp_stb = 1'b1;
      mcnt = 0;
      if (mdir == 0) begin
        if (mphase == PHMAX) begin mdir = 1; mphase--; end else mphase++;
      end else begin
        if (mphase == 0) begin mdir = 0; mphase = 1; end else mphase--;
      end
    end else begin
      exp_stb = 1'b0;
      mcnt++;
    end
  endtask

  task automatic release_reset();
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    @(negedge clk);
    check("R7 reset level", longint'(level), 0);
    check("R7 reset strobe", longint'(strobe), 0);
    // the next call to step predicts the third edge after release
  endtask

  initial begin
    rst_n = 1'b0; ref_s = '0; amp = '0; div = '0;
    void'($urandom(32'h5eed_1234));
    model_reset();
    repeat (3) @(negedge clk);
    check("R7 reset level", longint'(level), 0);
    check("R7 reset vector", longint'(cmp), 0);
    check("R7 reset strobe", longint'(strobe), 0);
    release_reset();

    // R10: zero amplitude pins the reference at the midpoint
    for (int i = 0; i < 40; i++) begin
      step(REF_W'($urandom), '0, '0);
      if (exp_stb) check("R10 midpoint level", longint'(exp_lvl), (LEVELS-1)/2);
    end

    // full-scale corners and every-cycle ticks
    for (int i = 0; i < 80; i++) begin
      step((i % 2) ? {1'b0, {(REF_W-1){1'b1}}} : {1'b1, {(REF_W-1){1'b0}}},
           {AMP_W{1'b1}}, '0);
    end

    // R9: a long divider, then lowered under the running count
    for (int i = 0; i < 6; i++) step(REF_W'($urandom), AMP_W'($urandom), 8'd9);
    step(REF_W'($urandom), AMP_W'($urandom), 8'd0);
    check("R9 early tick predicted", longint'(exp_stb), 1);

    // constrained random with divider 0..3
    for (int i = 0; i < 6000; i++) begin
      step(REF_W'($urandom), AMP_W'($urandom_range(0, (1 << AMP_W) - 1)),
           DIV_W'($urandom_range(0, 3)));
      if (strobe) begin
        checks++;
        if (((cmp + NC'(1)) & cmp) != '0) begin
          errors++;
          $display("FAIL R8 thermometer: actual %b expected thermometer", cmp);
        end
      end
    end

    // R7: reset in mid-run clears at once
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R7 mid-run reset level", longint'(level), 0);
    check("R7 mid-run reset vector", longint'(cmp), 0);
    release_reset();
    for (int i = 0; i < 2000; i++)
      step(REF_W'($urandom), AMP_W'($urandom), DIV_W'($urandom_range(0, 5)));
    @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule